// File: doc/BRIEF.md
# Packed SIMD Immediate-Operand ALU

This block is the execute stage for a group of 128-bit vector instructions that pair one source vector with a small constant from the instruction word. It decodes the 32-bit instruction, picks a lane width of 8, 16, 32 or 64 bits, and applies one operation to every lane at once. The operations are wrapping add and subtract, signed and unsigned maximum and minimum, equality, signed and unsigned less-than and less-or-equal, and a broadcast of a 10-bit signed constant into every lane. A compare writes a full lane mask.

The surrounding pipeline reads the source vector using the source index, which the block decodes combinationally, and presents that vector together with the instruction and a valid strobe. One cycle later the block returns the lane results, the destination index and a write enable. An encoding the block does not implement raises a reserved-instruction flag and no write takes place. The register file and the handling of the flag are outside the block.

Top module: `simd_imm_alu`

## Requirements
- R1: Bits [22:21] of the instruction select the lane width: 0 gives sixteen 8-bit lanes, 1 gives eight 16-bit lanes, 2 gives four 32-bit lanes and 3 gives two 64-bit lanes. Lane 0 occupies the least significant bits of the vector.
- R2: The 5-bit immediate is bits [20:16] and the source index is bits [15:11]. `src_idx` follows bits [15:11] in the same cycle. The destination index is bits [10:6] and appears on `dst_idx` with the result.
- R3: An instruction is implemented only when bits [31:26] are 011110. With bits [5:0] = 000110, bits [25:23] values 0 to 5 select add, subtract, signed max, unsigned max, signed min and unsigned min. With bits [5:0] = 000111, values 0, 2, 3, 4, 5 and 6 select equal, signed less-than, unsigned less-than, signed less-or-equal, unsigned less-or-equal and load-immediate.
- R4: Add and subtract use the immediate zero-extended to the lane width. The result is truncated to the lane, so it wraps on overflow.
- R5: Signed max and min use the immediate sign-extended and compare as two's-complement lane values. Unsigned max and min use it zero-extended and compare as unsigned lane values. The chosen value is written unchanged.
- R6: A compare writes all ones into a lane when it is true and all zeros when it is false. Equality and the signed compares use the sign-extended immediate. The unsigned compares use the zero-extended immediate.
- R7: Load-immediate takes a signed 10-bit value from bits [20:11]. It sign-extends the value, truncates it to the lane width, writes it into every lane, and ignores `src_vec`.
- R8: Any other encoding accepted with `in_valid` sets `rsvd_instr` one cycle later with `wr_en` low and a zero `result`.
- R9: The outputs are registered. An instruction accepted with `in_valid` produces `out_valid` on the next cycle. In a cycle without `in_valid`, the next cycle has `out_valid`, `wr_en` and `rsvd_instr` low, and `result` and `dst_idx` keep their values.
- R10: A synchronous active-low reset clears `out_valid`, `wr_en`, `rsvd_instr`, `result` and `dst_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and source vector are valid this cycle |
| instr | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector value |
| src_idx | output | 5 | Decoded source register index (combinational) |
| out_valid | output | 1 | A result slot is presented this cycle |
| wr_en | output | 1 | Write `result` to register `dst_idx` |
| rsvd_instr | output | 1 | The accepted encoding is not implemented |
| dst_idx | output | 5 | Destination register index |
| result | output | 128 | Lane results |

## Verification
The two events that can fall in the same cycle are presenting the result of one instruction and accepting the next one, which may be an unimplemented encoding. The bench issues instructions back to back, with a reserved encoding directly after a valid one. It requires the first result to keep its write enable and its lane values, and the reserved flag to appear only in the following slot, without a write. A sweep over every operation, every lane width and the immediates 0, 15, 16 and 31 is compared with a lane-by-lane reference model. The source lanes hold the signed and unsigned extremes.

// File: rtl/simd_imm_pkg.sv
// Shared definitions for the immediate-operand vector ALU.
// Assumes a fixed 32-bit instruction layout; vector width is set by the top.
package simd_imm_pkg;

    localparam logic [5:0] MAJOR_CODE = 6'b011110;
    localparam logic [5:0] MINOR_ARITH = 6'b000110;
    localparam logic [5:0] MINOR_CMP   = 6'b000111;
    localparam int         NUM_FMT     = 4;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_SMAX, OP_UMAX, OP_SMIN, OP_UMIN,
        OP_EQ, OP_SLT, OP_ULT, OP_SLE, OP_ULE, OP_LDI, OP_NONE
    } alu_op_e;

    // True for operations whose result lane is a full compare mask.
    function automatic logic is_compare(alu_op_e op);
        return (op == OP_EQ) || (op == OP_SLT) || (op == OP_ULT) ||
               (op == OP_SLE) || (op == OP_ULE);
    endfunction

endpackage

// File: rtl/simd_imm_decode.sv
// Instruction decoder: splits the word into format, immediates and indices,
// and maps the opcode fields to an operation. Purely combinational.
// Assumes the caller qualifies the outputs with its own valid strobe.
module simd_imm_decode
    import simd_imm_pkg::*;
(
    input  logic [31:0] instr,
    output alu_op_e     op,
    output logic [1:0]  fmt,
    output logic [4:0]  imm5,
    output logic [9:0]  imm10,
    output logic [4:0]  src,
    output logic [4:0]  dst,
    output logic        rsvd
);
    assign fmt   = instr[22:21];
    assign imm5  = instr[20:16];
    assign imm10 = instr[20:11];
    assign src   = instr[15:11];
    assign dst   = instr[10:6];

    // Opcode selection from the major code, minor code and sub-op bits.
    always_comb begin
        op = OP_NONE;
        if (instr[31:26] == MAJOR_CODE) begin
            if (instr[5:0] == MINOR_ARITH) begin
                case (instr[25:23])
                    3'd0:    op = OP_ADD;
                    3'd1:    op = OP_SUB;
                    3'd2:    op = OP_SMAX;
                    3'd3:    op = OP_UMAX;
                    3'd4:    op = OP_SMIN;
                    3'd5:    op = OP_UMIN;
                    default: op = OP_NONE;
                endcase
            end else if (instr[5:0] == MINOR_CMP) begin
                case (instr[25:23])
                    3'd0:    op = OP_EQ;
                    3'd2:    op = OP_SLT;
                    3'd3:    op = OP_ULT;
                    3'd4:    op = OP_SLE;
                    3'd5:    op = OP_ULE;
                    3'd6:    op = OP_LDI;
                    default: op = OP_NONE;
                endcase
            end
        end
    end

    assign rsvd = (op == OP_NONE);

endmodule

// File: rtl/simd_imm_lanes.sv
// One lane-width slice of the ALU: applies the decoded operation to every
// LANE_W-bit lane of the vector. Combinational.
// Assumes VEC_W is a multiple of LANE_W and LANE_W is at least 16 bits
// wider than nothing: LANE_W must be 8 or more and at most 64.
module simd_imm_lanes
    import simd_imm_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  alu_op_e           op,
    input  logic [4:0]        imm5,
    input  logic [9:0]        imm10,
    input  logic [VEC_W-1:0]  vec,
    output logic [VEC_W-1:0]  res
);
    localparam int NUM_LANES = VEC_W / LANE_W;

    // Immediates widened once for all lanes.
    logic signed [63:0] imm5_sx64;
    logic signed [63:0] imm10_sx64;
    logic [LANE_W-1:0]  imm_z;
    logic [LANE_W-1:0]  imm_s;
    logic [LANE_W-1:0]  ldi_val;

    assign imm5_sx64  = 64'(signed'(imm5));
    assign imm10_sx64 = 64'(signed'(imm10));
    assign imm_z      = LANE_W'(imm5);
    assign imm_s      = imm5_sx64[LANE_W-1:0];
    assign ldi_val    = imm10_sx64[LANE_W-1:0];

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] a;
        logic [LANE_W-1:0] r;
        logic              s_lt;
        logic              s_gt;

        assign a    = vec[i*LANE_W +: LANE_W];
        assign s_lt = $signed(a) < $signed(imm_s);
        assign s_gt = $signed(a) > $signed(imm_s);

        // Per-lane operation select.
        always_comb begin
            case (op)
                OP_ADD:  r = a + imm_z;
                OP_SUB:  r = a - imm_z;
                OP_SMAX: r = s_lt ? imm_s : a;
                OP_UMAX: r = (a < imm_z) ? imm_z : a;
                OP_SMIN: r = s_gt ? imm_s : a;
                OP_UMIN: r = (a > imm_z) ? imm_z : a;
                OP_EQ:   r = {LANE_W{a == imm_s}};
                OP_SLT:  r = {LANE_W{s_lt}};
                OP_ULT:  r = {LANE_W{a < imm_z}};
                OP_SLE:  r = {LANE_W{!s_gt}};
                OP_ULE:  r = {LANE_W{a <= imm_z}};
                OP_LDI:  r = ldi_val;
                default: r = '0;
            endcase
        end

        assign res[i*LANE_W +: LANE_W] = r;
    end

endmodule

// File: rtl/simd_imm_alu.sv
// Top of the immediate-operand vector ALU: decodes the instruction, computes
// all four lane widths in parallel, selects one by format and registers the
// result, destination index, write enable and reserved flag.
// Assumes the source vector arrives in the same cycle as the instruction.
module simd_imm_alu
    import simd_imm_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [VEC_W-1:0]  src_vec,
    output logic [4:0]        src_idx,
    output logic              out_valid,
    output logic              wr_en,
    output logic              rsvd_instr,
    output logic [4:0]        dst_idx,
    output logic [VEC_W-1:0]  result
);
    alu_op_e     op_d;
    alu_op_e     op_q;
    logic [1:0]  fmt_d;
    logic [4:0]  imm5_d;
    logic [9:0]  imm10_d;
    logic [4:0]  dst_d;
    logic        rsvd_d;
    logic [VEC_W-1:0] fmt_res [NUM_FMT];

    simd_imm_decode u_dec (
        .instr (instr),
        .op    (op_d),
        .fmt   (fmt_d),
        .imm5  (imm5_d),
        .imm10 (imm10_d),
        .src   (src_idx),
        .dst   (dst_d),
        .rsvd  (rsvd_d)
    );

    for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
        simd_imm_lanes #(
            .VEC_W  (VEC_W),
            .LANE_W (8 << f)
        ) u_lanes (
            .op    (op_d),
            .imm5  (imm5_d),
            .imm10 (imm10_d),
            .vec   (src_vec),
            .res   (fmt_res[f])
        );
    end

    // Output registers: capture on accept, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            wr_en      <= 1'b0;
            rsvd_instr <= 1'b0;
            dst_idx    <= '0;
            result     <= '0;
            op_q       <= OP_NONE;
        end else begin
            out_valid  <= in_valid;
            wr_en      <= in_valid && !rsvd_d;
            rsvd_instr <= in_valid && rsvd_d;
            if (in_valid) begin
                dst_idx <= dst_d;
                result  <= fmt_res[fmt_d];
                op_q    <= op_d;
            end
        end
    end

    AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_instr |-> (!wr_en && result == '0)); // R8
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(dst_idx) && !wr_en && !rsvd_instr)); // R9
    AST_WE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rsvd_instr) |-> out_valid); // R9
    AST_CMP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_compare(op_q)) |-> (result[7:0] == 8'h00 || result[7:0] == 8'hFF)); // R6

endmodule

// File: tb/simd_imm_alu_test.sv
module simd_imm_alu_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] src_vec = '0;
    logic [4:0]   src_idx;
    logic         out_valid;
    logic         wr_en;
    logic         rsvd_instr;
    logic [4:0]   dst_idx;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    simd_imm_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_vec(src_vec), .src_idx(src_idx), .out_valid(out_valid),
        .wr_en(wr_en), .rsvd_instr(rsvd_instr), .dst_idx(dst_idx),
        .result(result)
    );

    // Word builders (R3 field layout).
    function automatic logic [31:0] mk(input logic [5:0] minor, input logic [2:0] sub,
                                       input logic [1:0] fmt, input logic [4:0] imm,
                                       input logic [4:0] s, input logic [4:0] d);
        return {6'b011110, sub, fmt, imm, s, d, minor};
    endfunction

    function automatic logic [31:0] mk_ldi(input logic [1:0] fmt, input logic [9:0] v,
                                           input logic [4:0] d);
        return {6'b011110, 3'd6, fmt, v, d, 6'b000111};
    endfunction

    function automatic bit model_rsvd(input logic [31:0] ins);
        if (ins[31:26] != 6'b011110) return 1'b1;
        if (ins[5:0] == 6'b000110) return ins[25:23] > 3'd5;
        if (ins[5:0] == 6'b000111) return (ins[25:23] == 3'd1) || (ins[25:23] == 3'd7);
        return 1'b1;
    endfunction

    // Lane-by-lane reference model; signed order via sign-bit flip.
    function automatic logic [127:0] model(input logic [31:0] ins, input logic [127:0] v);
        logic [127:0] o = '0;
        int lw = 8 << ins[22:21];
        logic [63:0] mask = (lw == 64) ? '1 : ((64'd1 << lw) - 1);
        logic [63:0] sb = 64'd1 << (lw - 1);
        logic [63:0] zi = 64'(ins[20:16]);
        logic [63:0] si = {{59{ins[20]}}, ins[20:16]} & mask;
        logic [63:0] l10 = {{54{ins[20]}}, ins[20:11]} & mask;
        logic [3:0] code = {ins[0], ins[25:23]};
        if (model_rsvd(ins)) return '0;
        for (int i = 0; i < 128 / lw; i++) begin
            logic [63:0] a = 64'(v >> (i * lw)) & mask;
            logic [63:0] r;
            logic slt_as = (a ^ sb) < (si ^ sb);
            logic slt_sa = (si ^ sb) < (a ^ sb);
            case (code)
                4'd0:    r = a + zi;
                4'd1:    r = a - zi;
                4'd2:    r = slt_as ? si : a;
                4'd3:    r = (a < zi) ? zi : a;
                4'd4:    r = slt_sa ? si : a;
                4'd5:    r = (zi < a) ? zi : a;
                4'd8:    r = (a == si) ? '1 : '0;
                4'd10:   r = slt_as ? '1 : '0;
                4'd11:   r = (a < zi) ? '1 : '0;
                4'd12:   r = !slt_sa ? '1 : '0;
                4'd13:   r = (a <= zi) ? '1 : '0;
                default: r = l10;
            endcase
            o = o | (128'(r & mask) << (i * lw));
        end
        return o;
    endfunction

    // Source pattern per lane width: k=0 extremes, k=1 values near immediates.
    function automatic logic [127:0] pattern(input int fmt, input int k);
        logic [127:0] o = '0;
        int lw = 8 << fmt;
        logic [63:0] mask = (lw == 64) ? '1 : ((64'd1 << lw) - 1);
        logic [63:0] sb = 64'd1 << (lw - 1);
        for (int i = 0; i < 128 / lw; i++) begin
            logic [63:0] e;
            if (k == 0) e = (i % 4 == 0) ? sb : (i % 4 == 1) ? sb - 1 : (i % 4 == 2) ? mask : 64'd0;
            else        e = (i % 4 == 0) ? 64'd15 : (i % 4 == 1) ? 64'd16 : (i % 4 == 2) ? 64'd31 : mask;
            o = o | (128'(e & mask) << (i * lw));
        end
        return o;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one instruction for a cycle, then check the registered slot.
    task automatic run_one(input string req, input logic [31:0] ins, input logic [127:0] v);
        @(negedge clk);
        in_valid = 1'b1; instr = ins; src_vec = v;
        #1 check("R2", "src_idx", 128'(src_idx), 128'(ins[15:11]));
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "result", result, model(ins, v));
        check(req, "flags", {out_valid, wr_en, rsvd_instr},
              {1'b1, !model_rsvd(ins), model_rsvd(ins)});
        if (!model_rsvd(ins)) check("R2", "dst_idx", 128'(dst_idx), 128'(ins[10:6]));
    endtask

    // Directed table of encodings; bit 32 is the expected reserved flag (R3, R8).
    localparam logic [32:0] VEC_TAB [10] = '{
        {1'b0, 6'b011110, 3'd0, 2'd0, 5'd31, 5'd3, 5'd9, 6'b000110},
        {1'b0, 6'b011110, 3'd1, 2'd1, 5'd16, 5'd4, 5'd10, 6'b000110},
        {1'b0, 6'b011110, 3'd2, 2'd2, 5'd16, 5'd5, 5'd11, 6'b000110},
        {1'b0, 6'b011110, 3'd5, 2'd3, 5'd15, 5'd6, 5'd12, 6'b000110},
        {1'b1, 6'b011110, 3'd6, 2'd0, 5'd1, 5'd7, 5'd13, 6'b000110},
        {1'b1, 6'b011110, 3'd7, 2'd1, 5'd1, 5'd8, 5'd14, 6'b000110},
        {1'b1, 6'b011110, 3'd1, 2'd2, 5'd1, 5'd9, 5'd15, 6'b000111},
        {1'b1, 6'b011110, 3'd7, 2'd3, 5'd1, 5'd10, 5'd16, 6'b000111},
        {1'b1, 6'b011111, 3'd0, 2'd0, 5'd1, 5'd11, 5'd17, 6'b000110},
        {1'b1, 6'b011110, 3'd0, 2'd0, 5'd1, 5'd12, 5'd18, 6'b000101}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [127:0] first_res;
        logic [127:0] held;
        // R10: reset with garbage on the inputs.
        instr = 32'hFFFF_FFFF; src_vec = '1;
        repeat (3) @(negedge clk);
        check("R10", "reset outputs", {result, 3'(dst_idx), out_valid, wr_en, rsvd_instr},
              '0);
        rst_n = 1'b1;

        // Table walk: valid and reserved encodings.
        for (int t = 0; t < 10; t++) begin
            run_one(VEC_TAB[t][32] ? "R8" : "R3", VEC_TAB[t][31:0], pattern(t % 4, 0));
            check(VEC_TAB[t][32] ? "R8" : "R3", "table rsvd", 128'(rsvd_instr),
                  128'(VEC_TAB[t][32]));
        end

        // Sweep: every operation, lane width (R1), immediate, source pattern.
        for (int k = 0; k < 2; k++)
            for (int f = 0; f < 4; f++)
                for (int s = 0; s < 12; s++)
                    for (int m = 0; m < 4; m++) begin
                        logic [4:0] imm = (m == 0) ? 5'd0 : (m == 1) ? 5'd15 : (m == 2) ? 5'd16 : 5'd31;
                        logic [31:0] w;
                        string req;
                        if (s < 6) begin
                            w = mk(6'b000110, 3'(s), 2'(f), imm, 5'(s), 5'(m + 1));
                            req = (s < 2) ? "R4" : "R5";
                        end else if (s < 11) begin
                            logic [2:0] sub = (s == 6) ? 3'd0 : 3'(s - 5);
                            w = mk(6'b000111, sub, 2'(f), imm, 5'(s), 5'(m + 2));
                            req = "R6";
                        end else begin
                            w = mk_ldi(2'(f), {imm, imm}, 5'(f));
                            req = "R7";
                        end
                        run_one(f == 0 ? "R1" : req, w, pattern(f, k));
                    end

        // R7: load-immediate ignores the source; most negative 10-bit value.
        run_one("R7", mk_ldi(2'd1, 10'h200, 5'd1), '1);
        held = result;
        run_one("R7", mk_ldi(2'd1, 10'h200, 5'd1), '0);
        check("R7", "ldi source ignored", result, held);
        check("R7", "ldi halfword value", result, {8{16'hFE00}});

        // R4: byte add wrap 0xFF + 31 = 0x1E.
        run_one("R4", mk(6'b000110, 3'd0, 2'd0, 5'd31, 5'd0, 5'd0), '1);
        check("R4", "byte wrap", result, {16{8'h1E}});

        // R9: back-to-back, valid then reserved in the next cycle.
        @(negedge clk);
        in_valid = 1'b1; instr = mk(6'b000110, 3'd1, 2'd2, 5'd1, 5'd2, 5'd21); src_vec = '0;
        first_res = model(instr, src_vec);
        @(negedge clk);
        instr = mk(6'b000110, 3'd7, 2'd2, 5'd1, 5'd2, 5'd22);
        check("R9", "b2b first result", result, first_res);
        check("R9", "b2b first flags", {out_valid, wr_en, rsvd_instr, 5'(dst_idx)},
              {3'b110, 5'd21});
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "b2b reserved flags", {out_valid, wr_en, rsvd_instr}, 3'b101);

        // R9: idle cycles hold result and index, drop strobes.
        run_one("R9", mk(6'b000111, 3'd0, 2'd3, 5'd0, 5'd1, 5'd7), '0);
        held = result;
        repeat (3) @(negedge clk);
        check("R9", "idle hold", {result, 3'(dst_idx), out_valid, wr_en, rsvd_instr},
              {held, 3'd7, 3'b000});

        // R10: reset mid-stream clears held state.
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "reset after use", {result, 3'(dst_idx), out_valid, wr_en, rsvd_instr},
              '0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule